// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It watches three asynchronous control pins: a falling-edge trigger, a rising-edge trigger and an active-low clear. When a qualified event arrives, it drives a single pulse on a complementary output pair. The pulse length is a count of clock cycles, taken from a width input at the moment the pulse starts. Once a pulse is running, the trigger pins cannot stretch it, restart it or cut it short. Only the clear can end it early. A two-channel arrangement is two instances.

All three control pins pass through a synchroniser before any edge is detected. A trigger is therefore recognised two clock cycles after the pin changes, and the output rises one cycle after that. A third way to start a pulse is the release of the clear. It is honoured only when the rising-edge trigger went high while the clear was still asserted, and it uses that arming once. These are plain control pins with no handshake: a pin event that the block cannot use is dropped, not queued.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A high-to-low change on `trig_a_n`, seen while `trig_b` is high and `clear_n` is high, starts a pulse. `q` is still low at the second clock edge after the change and is high at the third.
- R2: A low-to-high change on `trig_b`, seen while `trig_a_n` is low and `clear_n` is high, starts a pulse.
- R3: While the synchronised `clear_n` is low, `q` is 0 and `q_n` is 1, whatever the triggers do. A clear that falls during a pulse ends it at the third clock edge after the fall.
- R4: A low-to-high change on `clear_n`, seen while `trig_a_n` is low and `trig_b` is high, starts a pulse only if `trig_b` rose while `clear_n` was low. A `trig_b` rise seen while `clear_n` is high does not arm this path.
- R5: While a pulse runs, changes on `trig_a_n` and `trig_b` neither extend, restart nor shorten it.
- R6: With `trig_a_n` held high, or with `trig_b` held low, toggling the other trigger starts no pulse. After reset the outputs rest at `q`=0 and `q_n`=1.
- R7: The clear-release arming is dropped when a pulse starts or when `trig_b` is low. A second clear release without a new `trig_b` rise starts nothing.
- R8: `q_n` is the complement of `q` in every cycle.
- R9: A pulse keeps `q` high for exactly the `pulse_len` value sampled at its start. A change to `pulse_len` during the pulse has no effect on it. A width of 1 gives a one-cycle pulse.
- R10: A trigger taken with `pulse_len` equal to 0 produces no pulse.
- R11: A trigger event that lands in the final high cycle of a pulse is discarded. A new pulse needs a fresh edge after `q` has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Asynchronous trigger; acts on a falling edge |
| trig_b | input | 1 | Asynchronous trigger; acts on a rising edge |
| clear_n | input | 1 | Asynchronous active-low clear; its release can also trigger |
| pulse_len | input | LEN_W | Pulse length in clock cycles, sampled when a pulse starts |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench uses the default parameters: an 8-bit length field and a two-stage synchroniser. Under these settings the three-edge latency and the final-cycle collision can be timed by hand. Short widths of 0, 1 and 4 to 20 cycles place the clear, width changes and extra trigger edges at chosen cycles inside a pulse. The width field goes up to 255, so a window of a few dozen cycles per scenario is enough to see every pulse end.

// File: rtl/os_pkg.sv
package os_pkg;

  typedef struct packed {
    logic a_n;
    logic b;
    logic clr_n;
  } os_ctl_t;

  localparam int CTL_W = $bits(os_ctl_t);

  // Idle levels: no trigger asserted, clear released.
  localparam os_ctl_t CTL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_CLR  = 2'd3
  } os_src_e;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
  import os_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  os_ctl_t cur,
  input  logic    busy,
  output logic    fire
);

  os_ctl_t prev_q;
  logic    arm_q;
  os_src_e src;

  logic a_fall, b_rise, c_rise;
  logic hit_a, hit_b, hit_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= CTL_IDLE;
    else        prev_q <= cur;
  end

  assign a_fall = prev_q.a_n & ~cur.a_n;
  assign b_rise = ~prev_q.b & cur.b;
  assign c_rise = ~prev_q.clr_n & cur.clr_n;

  assign hit_a = a_fall & cur.b & cur.clr_n;
  assign hit_b = b_rise & ~cur.a_n & cur.clr_n;
  assign hit_c = c_rise & ~cur.a_n & cur.b & arm_q;

  always_comb begin
    if (hit_a)      src = SRC_A;
    else if (hit_b) src = SRC_B;
    else if (hit_c) src = SRC_CLR;
    else            src = SRC_NONE;
  end

  assign fire = (src != SRC_NONE) & ~busy;

  // Clear-release arming: set by a B rise under clear, consumed by a start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      arm_q <= 1'b0;
    else if (fire || !cur.b)         arm_q <= 1'b0;
    else if (b_rise && !cur.clr_n)   arm_q <= 1'b1;
  end

  // R7: arming never survives a low B level
  assert_arm_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.b |=> !arm_q);

  // R4: arming only appears after a cycle with clear held low
  assert_arm_under_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> !$past(cur.clr_n));

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  input  logic             clr_ok,
  output logic             busy
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             run_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!clr_ok) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == ONE) run_q <= 1'b0;
      cnt_q <= cnt_q - ONE;
    end else if (fire && (len != '0)) begin
      run_q <= 1'b1;
      cnt_q <= len;
    end
  end

  assign busy = run_q;

  // R3: a low clear ends any pulse on the next edge
  assert_clear_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> !run_q);

  // R5: a running pulse only counts down, whatever the triggers do
  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && clr_ok && cnt_q != ONE) |=> (run_q && cnt_q == $past(cnt_q) - ONE));

  // R9: the width is captured at the start of the pulse
  assert_width_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == $past(len)));

  // R10: zero width never starts a pulse
  assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && len == '0 && !run_q) |=> !run_q);

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import os_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic             clear_n,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             q,
  output logic             q_n
);

  os_ctl_t raw_ctl;
  os_ctl_t sync_ctl;
  logic    fire;
  logic    busy;

  assign raw_ctl = '{a_n: trig_a_n, b: trig_b, clr_n: clear_n};

  os_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_ctl),
    .q    (sync_ctl)
  );

  os_trig_qual u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (sync_ctl),
    .busy (busy),
    .fire (fire)
  );

  os_pulse_timer #(
    .LEN_W(LEN_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .len   (pulse_len),
    .clr_ok(sync_ctl.clr_n),
    .busy  (busy)
  );

  assign q   = busy;
  assign q_n = ~busy;

  // R11: a trigger taken in the last high cycle does not restart the pulse
  assert_final_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |-> 1'b0);

endmodule

// File: tb/oneshot_pulse_gen_tb.sv
module oneshot_pulse_gen_tb;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_n = 1'b1, b = 1'b0, clr_n = 1'b1;
  logic [LEN_W-1:0] len = 8'd5;
  logic q, q_n;

  always #4 clk = ~clk;

  oneshot_pulse_gen #(.LEN_W(LEN_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clear_n(clr_n),
    .pulse_len(len), .q(q), .q_n(q_n));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R6";
  int hi_cnt = 0, rise_cnt = 0;
  logic q_last = 1'b0;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: inputs delayed by the pin-to-decision latency.
  bit [2:0] h1 = 3'b101, h2 = 3'b101, h3 = 3'b101; // {a_n, b, clr_n}
  bit m_run = 0, m_arm = 0;
  int m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 3'b101; h2 = 3'b101; h3 = 3'b101;
      m_run = 0; m_arm = 0; m_left = 0;
    end else begin
      bit fa, rb, rc, trig, go;
      fa = h3[2] && !h2[2];
      rb = !h3[1] && h2[1];
      rc = !h3[0] && h2[0];
      trig = (fa && h2[1] && h2[0]) || (rb && !h2[2] && h2[0]) ||
             (rc && !h2[2] && h2[1] && m_arm);
      go = trig && !m_run;
      if (go || !h2[1]) m_arm = 0;
      else if (rb && !h2[0]) m_arm = 1;
      if (!h2[0]) begin
        m_run = 0; m_left = 0;
      end else if (m_run) begin
        m_left--;
        if (m_left == 0) m_run = 0;
      end else if (go && len != 0) begin
        m_run = 1; m_left = int'(len);
      end
      h3 = h2; h2 = h1; h1 = {a_n, b, clr_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(q), int'(m_run), "q vs reference");
      chk("R8", int'(q_n), int'(!q), "q_n complement");
      if (q) hi_cnt++;
      if (q && !q_last) rise_cnt++;
      q_last = q;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_cnt();
    #1;
    hi_cnt = 0;
    rise_cnt = 0;
  endtask

  task automatic idle();
    a_n = 1; b = 0; clr_n = 1;
    cyc(10);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R6", int'(q), 0, "reset q");
    chk("R6", int'(q_n), 1, "reset q_n");
    cyc(4);

    // R1: falling A with B high, latency and width
    cur_req = "R1"; len = 5; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(2);
    chk("R1", int'(q), 0, "q before third edge");
    cyc(1);
    chk("R1", int'(q), 1, "q at third edge");
    cyc(10);
    chk("R1", hi_cnt, 5, "pulse width");
    chk("R1", rise_cnt, 1, "pulse count");
    idle();

    // R2: rising B with A low
    cur_req = "R2"; len = 7; a_n = 0; cyc(4); zero_cnt();
    b = 1; cyc(15);
    chk("R2", hi_cnt, 7, "pulse width");
    chk("R2", rise_cnt, 1, "pulse count");
    idle();

    // R5: trigger activity during a pulse
    cur_req = "R5"; len = 10; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(5); a_n = 1; cyc(1); a_n = 0; b = 0; cyc(1); b = 1;
    cyc(25);
    chk("R5", hi_cnt, 10, "width unchanged by retrigger");
    chk("R5", rise_cnt, 1, "single pulse");
    idle();

    // R9: width change mid-pulse, and width 1
    cur_req = "R9"; len = 6; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(4); len = 20; cyc(25);
    chk("R9", hi_cnt, 6, "width latched at start");
    idle();
    len = 1; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(10);
    chk("R9", hi_cnt, 1, "one-cycle pulse");
    idle();

    // R3: clear terminates, forces outputs, blocks triggers
    cur_req = "R3"; len = 20; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(8); clr_n = 0; cyc(3);
    chk("R3", int'(q), 0, "q after clear");
    chk("R3", int'(q_n), 1, "q_n after clear");
    chk("R3", hi_cnt, 8, "shortened width");
    a_n = 1; cyc(2); a_n = 0; cyc(6);
    chk("R3", int'(q), 0, "q held low under clear");
    clr_n = 1; cyc(12);
    chk("R4", rise_cnt, 1, "no clear-release pulse without arming");
    idle();

    // R4: armed clear-release trigger, then R7 consumption
    cur_req = "R4"; len = 5; clr_n = 0; a_n = 0; cyc(4); zero_cnt();
    b = 1; cyc(4); clr_n = 1; cyc(15);
    chk("R4", hi_cnt, 5, "clear-release pulse width");
    chk("R4", rise_cnt, 1, "clear-release pulse count");
    cur_req = "R7"; zero_cnt();
    clr_n = 0; cyc(4); clr_n = 1; cyc(15);
    chk("R7", rise_cnt, 0, "arming consumed by start");
    idle();

    // R4 negative: B rose while clear high
    cur_req = "R4"; b = 1; cyc(4); clr_n = 0; cyc(4); a_n = 0; cyc(4); zero_cnt();
    clr_n = 1; cyc(15);
    chk("R4", rise_cnt, 0, "B rise under released clear does not arm");
    idle();

    // R6: one trigger held inactive
    cur_req = "R6"; len = 5; zero_cnt();
    for (int i = 0; i < 4; i++) begin b = 1; cyc(3); b = 0; cyc(3); end
    chk("R6", rise_cnt, 0, "B toggles with A high");
    for (int i = 0; i < 4; i++) begin a_n = 0; cyc(3); a_n = 1; cyc(3); end
    cyc(5);
    chk("R6", rise_cnt, 0, "A toggles with B low");
    idle();

    // R10: zero width
    cur_req = "R10"; len = 0; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(12);
    chk("R10", hi_cnt, 0, "zero width gives no pulse");
    idle();

    // R11: edge in final cycle ignored, fresh edge accepted
    cur_req = "R11"; len = 4; b = 1; cyc(4); zero_cnt();
    a_n = 0; cyc(2); a_n = 1; cyc(2); a_n = 0; cyc(12);
    chk("R11", hi_cnt, 4, "width with final-cycle edge");
    chk("R11", rise_cnt, 1, "final-cycle edge discarded");
    a_n = 1; cyc(4); a_n = 0; cyc(12);
    chk("R11", rise_cnt, 2, "fresh edge after pulse");
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule